// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the target-side logic of a serial configuration memory that answers the read-identification command. While the active-low select is held low, it takes serial input bits on rising edges of the serial clock. It collects an 8-bit command code and then lets two filler bytes pass. After that it drives the identification byte on the serial output, most significant bit first. Output bits change on falling edges, so the host can capture each one on the next rising edge. When the block is not driving, the output is released to high impedance.

The memory core supplies a busy flag. If that flag is high when the command code completes, the request is dropped, and the erase or write in progress continues untouched. While select stays low after the last identification bit, the byte is sent again from its top bit. The host ends the exchange by raising select, which returns the block to its idle, undriven state at once. The command code, identification value and filler length are parameters.

Top module: `fid_responder`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `sdo_oe` is 0 and `sdo` is high impedance.
- R2: After `cs_n` falls, rising `sclk` edges 0 to 7 capture the command code MSB first from `sdi`, and edges 8 to 23 capture 16 filler bits whose values are ignored; `sdo_oe` stays 0 throughout these 24 edges.
- R3: For the code 8'h9F, the falling `sclk` edge after rising edge 23 raises `sdo_oe` and drives bit 7 of the identification value 8'h18. Each later falling edge drives the next lower bit, so the host reads bit 7-j at rising edge 24+j.
- R4: `core_busy` is sampled only at rising edge 7, where the last command bit arrives. If it is 1 there, the command is dropped and `sdo_oe` stays 0 until `cs_n` rises. A busy level at any other edge has no effect.
- R5: After bit 0 of the identification value, the next falling edge drives bit 7 again, and the byte repeats for as long as `cs_n` stays low.
- R6: Any command code other than 8'h9F leaves `sdo_oe` at 0 for the rest of the selection.
- R7: Raising `cs_n` at any point clears `sdo_oe` without waiting for a clock edge and discards all progress. The next falling `cs_n` starts a new command at edge 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| cs_n | input | 1 | Active-low select; high acts as an asynchronous reset |
| sdi | input | 1 | Serial command input, sampled on rising edges |
| core_busy | input | 1 | High while the memory core is erasing or writing |
| sdo | output | 1 | Serial identification output, high impedance when released |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
Command decode and the busy check happen on the same rising edge, because the busy flag is read on the edge that completes the command code. The bench raises `core_busy` for exactly that one edge and expects silence on the output. It then raises `core_busy` for only the following edge and expects a normal readout. It also raises `cs_n` part-way through a readout and checks that `sdo_oe` falls before the next edge and that a fresh command is answered in full.

// File: rtl/fid_pkg.sv
package fid_pkg;

    typedef enum logic [1:0] {
        PH_OPC   = 2'd0,
        PH_DUMMY = 2'd1,
        PH_SEND  = 2'd2,
        PH_DROP  = 2'd3
    } fid_phase_e;

endpackage

// File: rtl/fid_cmd_rx.sv
module fid_cmd_rx
    import fid_pkg::*;
#(
    parameter int              CMD_W      = 8,
    parameter logic [CMD_W-1:0] OPCODE    = 8'h9F,
    parameter int              DUMMY_BITS = 16
) (
    input  logic       sclk,
    input  logic       rst_n,
    input  logic       sdi,
    input  logic       core_busy,
    output fid_phase_e phase_o
);

    localparam int CNT_MAX = (CMD_W > DUMMY_BITS) ? CMD_W : DUMMY_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        fid_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-2:0] cmd;
    } rx_state_t;

    rx_state_t        s_d, s_q;
    logic [CMD_W-1:0] cmd_full;

    always_comb begin
        s_d      = s_q;
        cmd_full = {s_q.cmd, sdi};
        unique case (s_q.phase)
            PH_OPC: begin
                s_d.cmd = cmd_full[CMD_W-2:0];
                if (s_q.cnt == CNT_W'(CMD_W - 1)) begin
                    s_d.cnt = '0;
                    if (cmd_full == OPCODE && !core_busy) begin
                        s_d.phase = (DUMMY_BITS == 0) ? PH_SEND : PH_DUMMY;
                    end else begin
                        s_d.phase = PH_DROP;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DUMMY: begin
                if (s_q.cnt == CNT_W'(DUMMY_BITS - 1)) begin
                    s_d.cnt   = '0;
                    s_d.phase = PH_SEND;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d = s_q;
            end
        endcase
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_OPC, cnt: '0, cmd: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;

    // R4: busy on the last command edge drops the request
    a_r4_busy_drop: assert property (@(posedge sclk) disable iff (!rst_n)
        (s_q.phase == PH_OPC && s_q.cnt == CNT_W'(CMD_W - 1) && core_busy)
        |=> (s_q.phase == PH_DROP));

    // R6: a dropped selection stays dropped until select rises
    a_r6_drop_hold: assert property (@(posedge sclk) disable iff (!rst_n)
        (s_q.phase == PH_DROP) |=> (s_q.phase == PH_DROP));

    // R2: the filler counter never runs past its length
    a_r2_dummy_bound: assert property (@(posedge sclk) disable iff (!rst_n)
        (s_q.phase == PH_DUMMY) |-> (s_q.cnt < CNT_W'(DUMMY_BITS)));

endmodule

// File: rtl/fid_id_tx.sv
module fid_id_tx
    import fid_pkg::*;
#(
    parameter int              ID_W   = 8,
    parameter logic [ID_W-1:0] ID_VAL = 8'h18
) (
    input  logic       sclk,
    input  logic       rst_n,
    input  fid_phase_e phase_i,
    output logic       bit_o,
    output logic       oe_o
);

    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

    typedef struct packed {
        logic             oe;
        logic [IDX_W-1:0] idx;
        logic             bit_v;
    } tx_state_t;

    tx_state_t        t_d, t_q;
    logic [IDX_W-1:0] nidx;

    always_comb begin
        t_d  = t_q;
        nidx = (t_q.idx == '0) ? IDX_W'(ID_W - 1) : t_q.idx - 1'b1;
        if (phase_i == PH_SEND) begin
            if (!t_q.oe) begin
                t_d.oe    = 1'b1;
                t_d.idx   = IDX_W'(ID_W - 1);
                t_d.bit_v = ID_VAL[ID_W-1];
            end else begin
                t_d.idx   = nidx;
                t_d.bit_v = ID_VAL[nidx];
            end
        end else begin
            t_d.oe = 1'b0;
        end
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{oe: 1'b0, idx: '0, bit_v: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign bit_o = t_q.bit_v;
    assign oe_o  = t_q.oe;

    // R1 / R2: no drive unless the receiver has reached the send phase
    a_r2_quiet_before_send: assert property (@(negedge sclk) disable iff (!rst_n)
        (phase_i != PH_SEND) |=> !t_q.oe);

    // R3: first driven bit is the top bit of the identification value
    a_r3_first_msb: assert property (@(negedge sclk) disable iff (!rst_n)
        (!t_q.oe && phase_i == PH_SEND) |=> (t_q.oe && t_q.bit_v == ID_VAL[ID_W-1]));

    // R5: after bit 0 the readout restarts at the top bit
    a_r5_wrap_msb: assert property (@(negedge sclk) disable iff (!rst_n)
        (t_q.oe && phase_i == PH_SEND && t_q.idx == '0)
        |=> (t_q.idx == IDX_W'(ID_W - 1) && t_q.bit_v == ID_VAL[ID_W-1]));

endmodule

// File: rtl/fid_responder.sv
module fid_responder
    import fid_pkg::*;
#(
    parameter int              CMD_W       = 8,
    parameter logic [CMD_W-1:0] OPCODE     = 8'h9F,
    parameter int              DUMMY_BYTES = 2,
    parameter int              ID_W        = 8,
    parameter logic [ID_W-1:0] ID_VAL      = 8'h18
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sdi,
    input  logic core_busy,
    output logic sdo,
    output logic sdo_oe
);

    localparam int DUMMY_BITS = DUMMY_BYTES * 8;

    logic       sel_rst_n;
    fid_phase_e phase;
    logic       tx_bit;
    logic       tx_oe;

    assign sel_rst_n = rst_n & ~cs_n;

    fid_cmd_rx #(
        .CMD_W      (CMD_W),
        .OPCODE     (OPCODE),
        .DUMMY_BITS (DUMMY_BITS)
    ) u_rx (
        .sclk      (sclk),
        .rst_n     (sel_rst_n),
        .sdi       (sdi),
        .core_busy (core_busy),
        .phase_o   (phase)
    );

    fid_id_tx #(
        .ID_W   (ID_W),
        .ID_VAL (ID_VAL)
    ) u_tx (
        .sclk    (sclk),
        .rst_n   (sel_rst_n),
        .phase_i (phase),
        .bit_o   (tx_bit),
        .oe_o    (tx_oe)
    );

    assign sdo    = tx_oe ? tx_bit : 1'bz;
    assign sdo_oe = tx_oe;

    // R7: with select high the output is released on the rising clock edge too
    a_r7_release_on_deselect: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

endmodule

// File: tb/fid_responder_tb.sv
module fid_responder_tb;

    localparam logic [7:0] OPC_EXP = 8'h9F;
    localparam logic [7:0] ID_EXP  = 8'h18;

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic core_busy = 1'b0;
    wire  sdo_w;
    wire  oe_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  oe;
        logic  b;
        string req;
        int    cyc;
    } exp_t;

    exp_t q[$];

    always #10 sclk = ~sclk;

    fid_responder u_dut (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .core_busy (core_busy),
        .sdo       (sdo_w),
        .sdo_oe    (oe_w)
    );

    task automatic check_idle(input string req);
        checks++;
        if (oe_w !== 1'b0) begin
            errors++;
            $display("FAIL %s idle: sdo_oe=%b expected 0", req, oe_w);
        end
    endtask

    // driver: one command; every cycle pushes the expected output for its rising edge
    task automatic run_cmd(input logic [7:0] opc, input logic [15:0] dmy, input int total,
                           input int busy_at, input bit send, input string req);
        exp_t e;
        @(negedge sclk);
        #2 cs_n = 1'b0;
        for (int k = 0; k < total; k++) begin
            if (k > 0) begin
                @(negedge sclk);
                #2;
            end
            sdi       = (k < 8) ? opc[7-k] : (k < 24) ? dmy[23-k] : 1'b0;
            core_busy = (k == busy_at);
            e.oe  = send && (k >= 24);
            e.b   = (k >= 24) ? ID_EXP[7 - ((k - 24) % 8)] : 1'b0;
            e.req = req;
            e.cyc = k;
            q.push_back(e);
        end
        @(negedge sclk);
        #2 cs_n = 1'b1;
        core_busy = 1'b0;
        #3 check_idle("R7");
    endtask

    // monitor: compares in the middle of the high phase
    initial begin
        exp_t e;
        forever begin
            @(posedge sclk);
            #6;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (oe_w !== e.oe || (e.oe && sdo_w !== e.b)) begin
                    errors++;
                    $display("FAIL %s cycle %0d: oe=%b sdo=%b expected oe=%b sdo=%b",
                             e.req, e.cyc, oe_w, sdo_w, e.oe, e.b);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge sclk);
        #2 check_idle("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
        #2 check_idle("R1");

        // R2 R3 R5: two full readouts, plain filler
        run_cmd(OPC_EXP, 16'h0000, 40, -1, 1'b1, "R3/R5");
        // R2: filler content ignored
        run_cmd(OPC_EXP, 16'hA5FF, 40, -1, 1'b1, "R2");
        // R4: busy on the final command edge drops the request
        run_cmd(OPC_EXP, 16'h0000, 40, 7, 1'b0, "R4");
        // R4: busy one edge later has no effect
        run_cmd(OPC_EXP, 16'h0000, 40, 8, 1'b1, "R4");
        // R4: busy during readout has no effect
        run_cmd(OPC_EXP, 16'h0000, 40, 30, 1'b1, "R4");
        // R6: other codes stay silent
        run_cmd(8'h9E, 16'h0000, 40, -1, 1'b0, "R6");
        run_cmd(8'h03, 16'h0000, 40, -1, 1'b0, "R6");
        // R7: abort inside readout, then a fresh command
        run_cmd(OPC_EXP, 16'h0000, 27, -1, 1'b1, "R7");
        run_cmd(OPC_EXP, 16'h0000, 33, -1, 1'b1, "R7");
        // R7: abort inside the command code, then a fresh command
        run_cmd(OPC_EXP, 16'h0000, 4, -1, 1'b1, "R7");
        run_cmd(OPC_EXP, 16'h0000, 32, -1, 1'b1, "R7");

        repeat (3) @(negedge sclk);
        #2 check_idle("R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule